// File: doc/BRIEF.md
# Process ID address relocation unit

This block sits on the virtual address outputs of a processor core, in front of the caches, the MMU and the tightly coupled memory. It holds a 7-bit process identifier. Any address in the lowest 32 MB window is moved into the 32 MB slot of the current process. Each process then sees the same low addresses while the downstream tags stay distinct, so a context switch needs no cache or TLB flush.

There are two combinational address paths, one for instruction fetch and one for data, and each produces a modified virtual address. Relocation is bypassed when the MMU is off. The data path also bypasses it for entry-based cache or TLB maintenance accesses. After a new identifier is written, the fetch path keeps the old identifier for two more fetches. This matches instructions already fetched under the old identifier.

Top module: `pid_reloc_unit`

## Requirements
- R1: After reset the identifier is zero and a read returns all zeros. Both paths then map flat, so each output equals its input.
- R2: With the MMU on, a data address whose bits 31:25 are all zero and that is not flagged as maintenance is output as the address plus identifier times 32 MB. This is the same as replacing bits 31:25 with the identifier.
- R3: An address of 32 MB or above, where bits 31:25 are not all zero, passes through unchanged on both paths.
- R4: While `mmu_on` is low, neither path relocates: `if_mva` equals `if_va` and `d_mva` equals `d_va`.
- R5: While `d_maint` is high, `d_mva` equals `d_va` whatever the identifier.
- R6: A write stores `reg_wr_data[31:25]` as the identifier and ignores bits 24:0. The read port returns the identifier in bits 31:25 and zeros below, and it shows a written value from the cycle after the write.
- R7: The data path uses a newly written identifier from the cycle after the write.
- R8: After a write, the next two cycles with `if_valid` high still relocate with the old identifier, and the third fetch uses the new one. A fetch in the write cycle itself is not counted. Cycles without `if_valid` do not advance the count.
- R9: A write during the two-fetch window restarts the count. When the window closes, the fetch path uses the latest written value.
- R10: Both paths are combinational, so a modified address is valid in the same cycle as its input address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the identifier register |
| reg_wr_data | input | 32 | Write data; identifier in bits 31:25 |
| reg_rd_data | output | 32 | Read data; identifier in bits 31:25, zeros below |
| mmu_on | input | 1 | MMU enable; low disables relocation |
| if_valid | input | 1 | Instruction fetch handshake taken this cycle |
| if_va | input | 32 | Fetch virtual address |
| if_mva | output | 32 | Fetch modified virtual address |
| d_va | input | 32 | Data virtual address |
| d_maint | input | 1 | Data access is an entry-based cache/TLB maintenance operation |
| d_mva | output | 32 | Data modified virtual address |

## Verification
Two events can land in the same cycle: an identifier write and a fetch handshake. A write can also land on the last fetch that would close the pending window. The bench drives writes with `if_valid` high in the same cycle, and it also issues a second write on the exact fetch that would have switched the fetch identifier. It judges the result by the fetch output over the following fetches, which must keep the old identifier for two more counted fetches and then switch to the latest value. In the same runs the data output must switch one cycle after each write.

// File: rtl/pid_reloc_pkg.sv
package pid_reloc_pkg;
  localparam int unsigned ADDR_W_DEF    = 32;
  localparam int unsigned PID_W_DEF     = 7;
  localparam int unsigned FETCH_LAG_DEF = 2;

  // Index of each relocation path in the generated array
  typedef enum logic {
    PATH_FETCH = 1'b0,
    PATH_DATA  = 1'b1
  } path_e;
endpackage

// File: rtl/addr_reloc.sv
module addr_reloc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PID_W  = 7
) (
  input  logic [ADDR_W-1:0] va,
  input  logic [PID_W-1:0]  pid,
  input  logic              enable,
  output logic [ADDR_W-1:0] mva
);
  localparam int unsigned LOW_W = ADDR_W - PID_W;

  logic in_window;

  always_comb begin
    in_window = (va[ADDR_W-1 -: PID_W] == '0);
    if (enable && in_window) begin
      mva = {pid, va[LOW_W-1:0]};
    end else begin
      mva = va;
    end
  end
endmodule

// File: rtl/pid_store.sv
module pid_store #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PID_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [PID_W-1:0]  pid_q,
  output logic [ADDR_W-1:0] rd_data
);
  localparam int unsigned LOW_W = ADDR_W - PID_W;

  logic [PID_W-1:0] pid_d;

  always_comb begin
    pid_d = wr_data[ADDR_W-1 -: PID_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_q <= '0;
    end else if (wr_en) begin
      pid_q <= pid_d;
    end
  end

  assign rd_data = {pid_q, {LOW_W{1'b0}}};
endmodule

// File: rtl/fetch_lag.sv
module fetch_lag #(
  parameter int unsigned PID_W     = 7,
  parameter int unsigned FETCH_LAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             fetch_fire,
  input  logic [PID_W-1:0] cur_pid,
  output logic [PID_W-1:0] fetch_pid
);
  localparam int unsigned CNT_W = $clog2(FETCH_LAG + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PID_W-1:0] fpid_d;
  logic             busy;
  logic             upd_en;

  always_comb begin
    busy   = (cnt_q != '0);
    upd_en = wr_en | (fetch_fire & busy);
    cnt_d  = cnt_q;
    fpid_d = fetch_pid;
    if (wr_en) begin
      cnt_d = CNT_W'(FETCH_LAG);
    end else if (fetch_fire && busy) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        fpid_d = cur_pid;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      fetch_pid <= '0;
    end else if (upd_en) begin
      cnt_q     <= cnt_d;
      fetch_pid <= fpid_d;
    end
  end
endmodule

// File: rtl/pid_reloc_unit.sv
module pid_reloc_unit
  import pid_reloc_pkg::*;
#(
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned PID_W     = PID_W_DEF,
  parameter int unsigned FETCH_LAG = FETCH_LAG_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_data,
  output logic [ADDR_W-1:0] reg_rd_data,
  input  logic              mmu_on,
  input  logic              if_valid,
  input  logic [ADDR_W-1:0] if_va,
  output logic [ADDR_W-1:0] if_mva,
  input  logic [ADDR_W-1:0] d_va,
  input  logic              d_maint,
  output logic [ADDR_W-1:0] d_mva
);
  localparam int unsigned N_PATH = 2;

  logic [PID_W-1:0]  cur_pid;
  logic [PID_W-1:0]  fetch_pid;
  logic [PID_W-1:0]  path_pid [N_PATH];
  logic [ADDR_W-1:0] path_va  [N_PATH];
  logic [ADDR_W-1:0] path_mva [N_PATH];
  logic              path_en  [N_PATH];

  pid_store #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .pid_q   (cur_pid),
    .rd_data (reg_rd_data)
  );

  fetch_lag #(.PID_W(PID_W), .FETCH_LAG(FETCH_LAG)) u_lag (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .fetch_fire (if_valid),
    .cur_pid    (cur_pid),
    .fetch_pid  (fetch_pid)
  );

  always_comb begin
    path_pid[PATH_FETCH] = fetch_pid;
    path_va[PATH_FETCH]  = if_va;
    path_en[PATH_FETCH]  = mmu_on;
    path_pid[PATH_DATA]  = cur_pid;
    path_va[PATH_DATA]   = d_va;
    path_en[PATH_DATA]   = mmu_on & ~d_maint;
  end

  for (genvar g = 0; g < N_PATH; g++) begin : g_path
    addr_reloc #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_reloc (
      .va     (path_va[g]),
      .pid    (path_pid[g]),
      .enable (path_en[g]),
      .mva    (path_mva[g])
    );
  end

  assign if_mva = path_mva[PATH_FETCH];
  assign d_mva  = path_mva[PATH_DATA];
endmodule

// File: rtl/pid_reloc_chk.sv
module pid_reloc_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PID_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_wr_data,
  input logic [ADDR_W-1:0] reg_rd_data,
  input logic              mmu_on,
  input logic [ADDR_W-1:0] if_va,
  input logic [ADDR_W-1:0] if_mva,
  input logic [ADDR_W-1:0] d_va,
  input logic              d_maint,
  input logic [ADDR_W-1:0] d_mva
);
  localparam int unsigned LOW_W = ADDR_W - PID_W;

  // R3
  high_fetch_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_va[ADDR_W-1 -: PID_W] != '0) |-> (if_mva == if_va));

  // R3
  high_data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_va[ADDR_W-1 -: PID_W] != '0) |-> (d_mva == d_va));

  // R4
  mmu_off_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mmu_on |-> ((if_mva == if_va) && (d_mva == d_va)));

  // R5
  maint_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_maint |-> (d_mva == d_va));

  // R6
  rd_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[LOW_W-1:0] == '0);

  // R6
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> (reg_rd_data[ADDR_W-1 -: PID_W] == $past(reg_wr_data[ADDR_W-1 -: PID_W])));

  // R7
  data_new_pid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mmu_on && !d_maint && d_va[ADDR_W-1 -: PID_W] == '0)
    |-> (d_mva[ADDR_W-1 -: PID_W] == reg_rd_data[ADDR_W-1 -: PID_W]));

  // R10
  low_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_mva[LOW_W-1:0] == if_va[LOW_W-1:0]) && (d_mva[LOW_W-1:0] == d_va[LOW_W-1:0]));
endmodule

bind pid_reloc_unit pid_reloc_chk #(.ADDR_W(ADDR_W), .PID_W(PID_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_data (reg_rd_data),
  .mmu_on      (mmu_on),
  .if_va       (if_va),
  .if_mva      (if_mva),
  .d_va        (d_va),
  .d_maint     (d_maint),
  .d_mva       (d_mva)
);

// File: tb/test_pid_reloc_unit.sv
module test_pid_reloc_unit;
  localparam logic [31:0] SLOT = 32'h0200_0000;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic [31:0] reg_wr_data;
  logic [31:0] reg_rd_data;
  logic        mmu_on;
  logic        if_valid;
  logic [31:0] if_va;
  logic [31:0] if_mva;
  logic [31:0] d_va;
  logic        d_maint;
  logic [31:0] d_mva;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // Reference state derived from R6..R9
  logic [6:0] m_cur;
  logic [6:0] m_fetch;
  int         m_left;

  pid_reloc_unit i_pid_reloc_unit (
    .clk (clk), .rst_n (rst_n),
    .reg_wr_en (reg_wr_en), .reg_wr_data (reg_wr_data), .reg_rd_data (reg_rd_data),
    .mmu_on (mmu_on), .if_valid (if_valid), .if_va (if_va), .if_mva (if_mva),
    .d_va (d_va), .d_maint (d_maint), .d_mva (d_mva)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] expect_addr(input logic [31:0] va, input logic [6:0] pid,
                                              input logic on, input logic mnt);
    if (!on || mnt || va >= SLOT) return va;
    return va + 32'(pid) * SLOT;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check combinational outputs, then
  // advance the reference model across the rising edge.
  task automatic step(input string req, input logic wr, input logic [31:0] wd,
                      input logic fv, input logic [31:0] fva, input logic [31:0] dva,
                      input logic mnt, input logic on);
    @(negedge clk);
    reg_wr_en = wr; reg_wr_data = wd; if_valid = fv; if_va = fva;
    d_va = dva; d_maint = mnt; mmu_on = on;
    #1;
    check(req, "if_mva", if_mva, expect_addr(fva, m_fetch, on, 1'b0));
    check(req, "d_mva", d_mva, expect_addr(dva, m_cur, on, mnt));
    check("R6", "rd_data", reg_rd_data, {m_cur, 25'd0});
    @(posedge clk);
    if (wr) begin
      m_cur  = wd[31:25];
      m_left = 2;
    end else if (fv && m_left != 0) begin
      m_left--;
      if (m_left == 0) m_fetch = m_cur;
    end
  endtask

  initial begin
    #200000ns;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 0; reg_wr_data = '0; mmu_on = 1; if_valid = 0;
    if_va = '0; d_va = '0; d_maint = 0;
    m_cur = '0; m_fetch = '0; m_left = 0;
    #12 rst_n = 1'b1;

    // R1: reset state, flat mapping
    step("R1", 0, 0, 1, 32'h0000_1234, 32'h01FF_FFFC, 0, 1);
    step("R1", 0, 0, 0, 32'h01AB_CDE0, 32'h0000_0000, 0, 1);

    // R2, R3, R4, R5, R6, R7, R10: sweep every identifier
    for (int p = 0; p < 128; p++) begin
      logic [31:0] lo = {7'd0, 25'(p * 32'h3_1F05)};
      step("R6", 1, {7'(p), 25'h1AB_CDEF}, 0, lo, lo, 0, 1);
      step("R7", 0, 0, 0, lo, lo ^ 32'h0100_0001, 0, 1);
      step("R3", 0, 0, 0, {7'(p) | 7'd1, lo[24:0]}, 32'hFFFF_FFF0 - lo, 0, 1);
      step("R4", 0, 0, 1, lo, lo, 0, 0);
      step("R5", 0, 0, 1, lo, lo, 1, 1);
      step("R2", 0, 0, 1, 32'h01FF_FFFF, lo, 0, 1);
      step("R10", 0, 0, 1, 32'h0000_0004, 32'h01FF_FFFF, 0, 1);
    end

    // R8: idle cycles do not count, two fetches keep the old identifier
    step("R8", 1, 32'h2200_0000, 0, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 32'h100, 32'h100, 0, 1);
    step("R8", 0, 0, 1, 32'h104, 32'h104, 0, 1);
    step("R8", 0, 0, 0, 32'h108, 32'h108, 0, 1);
    step("R8", 0, 0, 1, 32'h108, 32'h108, 0, 1);
    step("R8", 0, 0, 1, 32'h10C, 32'h10C, 0, 1);

    // R8: fetch in the write cycle is not counted
    step("R8", 1, 32'h4400_0000, 1, 32'h200, 32'h200, 0, 1);
    step("R8", 0, 0, 1, 32'h204, 32'h204, 0, 1);
    step("R8", 0, 0, 1, 32'h208, 32'h208, 0, 1);
    step("R8", 0, 0, 1, 32'h20C, 32'h20C, 0, 1);

    // R9: second write on the closing fetch restarts the window
    step("R9", 1, 32'h0600_0000, 0, 0, 0, 0, 1);
    step("R9", 0, 0, 1, 32'h300, 32'h300, 0, 1);
    step("R9", 1, 32'hFE00_0000, 1, 32'h304, 32'h304, 0, 1);
    step("R9", 0, 0, 1, 32'h308, 32'h308, 0, 1);
    step("R9", 0, 0, 1, 32'h30C, 32'h30C, 0, 1);
    step("R9", 0, 0, 1, 32'h310, 32'h310, 0, 1);
    step("R9", 0, 0, 1, 32'h0200_0000, 32'h314, 0, 1);

    // R1: reset returns to flat mapping
    @(negedge clk); rst_n = 1'b0; #1 rst_n = 1'b1;
    m_cur = '0; m_fetch = '0; m_left = 0;
    step("R1", 0, 0, 1, 32'h0000_0040, 32'h0000_0080, 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule